// File: doc/BRIEF.md
# Dual-Port Word Memory with Mailbox Interrupts

This block is a word memory that two agents reach at once through two fully independent ports, left and right. Each port has its own active-low chip enable, a read/write select, an output enable and a pair of active-low byte-lane selects. With these a port can read or write the upper byte, the lower byte or the whole word. Reads are registered: data appears on the read bus one clock after the request. A lane that is not selected, or a port whose output is not enabled, drives zero on the read bus in place of a floating bus.

The two highest word addresses also serve as a doorbell between the agents. A write by the left port to the top address pulls the right port's interrupt low. A write by the right port to the address just below the top pulls the left port's interrupt low. Each side drops its own interrupt by accessing its own mailbox with chip enable and output enable both active. The mailbox words keep their normal storage function, so software that ignores the interrupts sees plain memory.

An external arbiter supplies one active-low busy input per port. While a port's busy input is low, its memory writes are blocked and any mailbox set or clear it would cause is ignored. Depth and word width are parameters.

Top module: `mbox_dpram`

## Requirements
- R1: A read request (chip enable low, read/write high, output enable low) returns the stored word on that port's read bus in the following cycle.
- R2: The byte-lane selects act per lane: lane select bit 1 covers data bits [15:8] and bit 0 covers bits [7:0]. A write changes only the lanes whose select is low. A read returns zero in every lane whose select is high.
- R3: The read bus is all zero in the cycle after any cycle in which the port had chip enable high, read/write low or output enable high.
- R4: A left-port write (chip enable low, read/write low, busy high) to the top address 2^ADDR_W-1 drives the right interrupt low from the next cycle on.
- R5: A right-port write to address 2^ADDR_W-2 drives the left interrupt low from the next cycle on.
- R6: A port with busy high, chip enable low and output enable low at its own mailbox releases its interrupt high in the next cycle, whatever its read/write level. The right port's mailbox is the top address; the left port's is the one below it.
- R7: While a port's busy input is low, its writes leave the memory unchanged and its mailbox set or clear leaves the interrupt flags unchanged.
- R8: Both mailbox words are ordinary storage that either port can write and read back.
- R9: When a set and a clear of the same interrupt fall in the same cycle, the interrupt ends up low.
- R10: After reset both interrupts are high and both read buses are zero.
- R11: When both ports write the same address in one cycle, the left port's data wins in every lane both ports write. A lane only the right port writes takes the right port's data.
- R12: A read of an address that either port writes in the same cycle returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_ce_n | input | 1 | Left chip enable, active low |
| lt_we_n | input | 1 | Left read/write select, low writes |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_lane_n | input | DATA_W/8 | Left byte-lane selects, active low, bit 1 upper |
| lt_addr | input | ADDR_W | Left word address |
| lt_wdata | input | DATA_W | Left write data |
| lt_busy_n | input | 1 | Left busy from arbiter, low blocks writes and mailbox actions |
| lt_rdata | output | DATA_W | Left read data, one cycle latency |
| lt_int_n | output | 1 | Left interrupt, active low |
| rt_ce_n | input | 1 | Right chip enable, active low |
| rt_we_n | input | 1 | Right read/write select, low writes |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_lane_n | input | DATA_W/8 | Right byte-lane selects, active low, bit 1 upper |
| rt_addr | input | ADDR_W | Right word address |
| rt_wdata | input | DATA_W | Right write data |
| rt_busy_n | input | 1 | Right busy from arbiter |
| rt_rdata | output | DATA_W | Right read data, one cycle latency |
| rt_int_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 16. The 64-word array is small enough to fill completely and model in full. Random addresses then land on the two mailbox words often enough that sets and clears collide with each other and with busy. Same-address collisions between the ports also happen on many cycles, which exercises the write priority and the read-before-write ordering.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;
    localparam int LANE_W = 8;

    typedef struct packed {
        logic lt;
        logic rt;
    } flag_pair_t;
endpackage

// File: rtl/mbox_dpram_lane.sv
module mbox_dpram_lane #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [LANE_W-1:0] a_wd,
    output logic [LANE_W-1:0] a_rd,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [LANE_W-1:0] b_wd,
    output logic [LANE_W-1:0] b_rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] store [DEPTH];
    logic              b_wins;

    // the A side (left) takes priority when both hit the same word
    always_comb b_wins = b_wr && !(a_wr && (a_addr == b_addr));

    always_ff @(posedge clk) begin
        a_rd <= store[a_addr];
        b_rd <= store[b_addr];
        if (a_wr)   store[a_addr] <= a_wd;
        if (b_wins) store[b_addr] <= b_wd;
    end
endmodule

// File: rtl/mbox_dpram_port.sv
module mbox_dpram_port #(
    parameter int              ADDR_W  = 10,
    parameter int              LANES   = 2,
    parameter logic [ADDR_W-1:0] OWN_MB  = '1,
    parameter logic [ADDR_W-1:0] PEER_MB = '1
) (
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic [LANES-1:0]  wr_lanes,
    output logic [LANES-1:0]  rd_lanes,
    output logic              peer_set,
    output logic              own_clr
);
    logic wr_cyc;

    always_comb begin
        wr_cyc   = !ce_n && !we_n && busy_n;
        wr_lanes = wr_cyc ? ~lane_n : '0;
        rd_lanes = (!ce_n && we_n && !oe_n) ? ~lane_n : '0;
        peer_set = wr_cyc && (addr == PEER_MB);
        own_clr  = !ce_n && !oe_n && busy_n && (addr == OWN_MB);
    end
endmodule

// File: rtl/mbox_dpram_irq.sv
module mbox_dpram_irq
    import mbox_dpram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lt_set,
    input  logic lt_clr,
    input  logic rt_set,
    input  logic rt_clr,
    output logic lt_int_n,
    output logic rt_int_n
);
    flag_pair_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (lt_clr) flag_d.lt = 1'b0;
        if (lt_set) flag_d.lt = 1'b1;
        if (rt_clr) flag_d.rt = 1'b0;
        if (rt_set) flag_d.rt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign lt_int_n = !flag_q.lt;
    assign rt_int_n = !flag_q.rt;
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
    import mbox_dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lt_ce_n,
    input  logic                     lt_we_n,
    input  logic                     lt_oe_n,
    input  logic [DATA_W/LANE_W-1:0] lt_lane_n,
    input  logic [ADDR_W-1:0]        lt_addr,
    input  logic [DATA_W-1:0]        lt_wdata,
    input  logic                     lt_busy_n,
    output logic [DATA_W-1:0]        lt_rdata,
    output logic                     lt_int_n,
    input  logic                     rt_ce_n,
    input  logic                     rt_we_n,
    input  logic                     rt_oe_n,
    input  logic [DATA_W/LANE_W-1:0] rt_lane_n,
    input  logic [ADDR_W-1:0]        rt_addr,
    input  logic [DATA_W-1:0]        rt_wdata,
    input  logic                     rt_busy_n,
    output logic [DATA_W-1:0]        rt_rdata,
    output logic                     rt_int_n
);
    localparam int                LANES  = DATA_W / LANE_W;
    localparam logic [ADDR_W-1:0] MB_RT  = '1;
    localparam logic [ADDR_W-1:0] MB_LT  = MB_RT - 1'b1;

    typedef struct packed {
        logic [LANES-1:0] lt_vld;
        logic [LANES-1:0] rt_vld;
    } rd_state_t;

    rd_state_t        rs_d, rs_q;
    logic [LANES-1:0] lt_wr, lt_rd, rt_wr, rt_rd;
    logic             lt_peer_set, lt_own_clr, rt_peer_set, rt_own_clr;
    logic [DATA_W-1:0] lt_raw, rt_raw;

    mbox_dpram_port #(
        .ADDR_W(ADDR_W), .LANES(LANES), .OWN_MB(MB_LT), .PEER_MB(MB_RT)
    ) u_lt_port (
        .ce_n(lt_ce_n), .we_n(lt_we_n), .oe_n(lt_oe_n), .lane_n(lt_lane_n),
        .addr(lt_addr), .busy_n(lt_busy_n), .wr_lanes(lt_wr), .rd_lanes(lt_rd),
        .peer_set(lt_peer_set), .own_clr(lt_own_clr)
    );

    mbox_dpram_port #(
        .ADDR_W(ADDR_W), .LANES(LANES), .OWN_MB(MB_RT), .PEER_MB(MB_LT)
    ) u_rt_port (
        .ce_n(rt_ce_n), .we_n(rt_we_n), .oe_n(rt_oe_n), .lane_n(rt_lane_n),
        .addr(rt_addr), .busy_n(rt_busy_n), .wr_lanes(rt_wr), .rd_lanes(rt_rd),
        .peer_set(rt_peer_set), .own_clr(rt_own_clr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mbox_dpram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .a_wr  (lt_wr[g]),
            .a_addr(lt_addr),
            .a_wd  (lt_wdata[g*LANE_W +: LANE_W]),
            .a_rd  (lt_raw[g*LANE_W +: LANE_W]),
            .b_wr  (rt_wr[g]),
            .b_addr(rt_addr),
            .b_wd  (rt_wdata[g*LANE_W +: LANE_W]),
            .b_rd  (rt_raw[g*LANE_W +: LANE_W])
        );
        assign lt_rdata[g*LANE_W +: LANE_W] = rs_q.lt_vld[g] ? lt_raw[g*LANE_W +: LANE_W] : '0;
        assign rt_rdata[g*LANE_W +: LANE_W] = rs_q.rt_vld[g] ? rt_raw[g*LANE_W +: LANE_W] : '0;
    end

    mbox_dpram_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .lt_set(rt_peer_set), .lt_clr(lt_own_clr),
        .rt_set(lt_peer_set), .rt_clr(rt_own_clr),
        .lt_int_n(lt_int_n), .rt_int_n(rt_int_n)
    );

    always_comb begin
        rs_d        = rs_q;
        rs_d.lt_vld = lt_rd;
        rs_d.rt_vld = rt_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lt_ce_n,
    input logic                  lt_we_n,
    input logic                  lt_oe_n,
    input logic [ADDR_W-1:0]     lt_addr,
    input logic                  lt_busy_n,
    input logic [DATA_W-1:0]     lt_rdata,
    input logic                  lt_int_n,
    input logic                  rt_ce_n,
    input logic                  rt_we_n,
    input logic                  rt_oe_n,
    input logic [ADDR_W-1:0]     rt_addr,
    input logic                  rt_busy_n,
    input logic [DATA_W-1:0]     rt_rdata,
    input logic                  rt_int_n
);
    localparam logic [ADDR_W-1:0] TOP = '1;
    localparam logic [ADDR_W-1:0] NXT = TOP - 1'b1;

    logic l_sets, r_sets, l_clrs, r_clrs;
    assign l_sets = !lt_ce_n && !lt_we_n && lt_busy_n && lt_addr == TOP;
    assign r_sets = !rt_ce_n && !rt_we_n && rt_busy_n && rt_addr == NXT;
    assign r_clrs = !rt_ce_n && !rt_oe_n && rt_busy_n && rt_addr == TOP;
    assign l_clrs = !lt_ce_n && !lt_oe_n && lt_busy_n && lt_addr == NXT;

    AST_RT_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        l_sets |=> !rt_int_n); // R4
    AST_LT_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        r_sets |=> !lt_int_n); // R5
    AST_RT_INT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_clrs && !l_sets) |=> rt_int_n); // R6
    AST_RT_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sets && !r_clrs) |=> $stable(rt_int_n)); // R7
    AST_LT_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_sets && !l_clrs) |=> $stable(lt_int_n)); // R7
    AST_LT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_ce_n || !lt_we_n || lt_oe_n) |=> (lt_rdata == '0)); // R3
    AST_RT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_ce_n || !rt_we_n || rt_oe_n) |=> (rt_rdata == '0)); // R3
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lt_ce_n(lt_ce_n), .lt_we_n(lt_we_n), .lt_oe_n(lt_oe_n), .lt_addr(lt_addr),
    .lt_busy_n(lt_busy_n), .lt_rdata(lt_rdata), .lt_int_n(lt_int_n),
    .rt_ce_n(rt_ce_n), .rt_we_n(rt_we_n), .rt_oe_n(rt_oe_n), .rt_addr(rt_addr),
    .rt_busy_n(rt_busy_n), .rt_rdata(rt_rdata), .rt_int_n(rt_int_n)
);

// File: tb/mbox_dpram_tb_top.sv
module mbox_dpram_tb_top;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] NXT = TOP - 1'b1;

    typedef struct {
        logic          ce_n, we_n, oe_n;
        logic [1:0]    ln;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          busy_n;
    } pin_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    pin_t pl, pr;
    logic [DW-1:0] lt_rdata, rt_rdata;
    logic lt_int_n, rt_int_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] mem_m [DEPTH];
    bit            fl_l = 1'b0, fl_r = 1'b0;
    logic [DW-1:0] exp_lrd = '0, exp_rrd = '0;
    string         prev_tag = "R10 reset";

    always #2.5 clk = ~clk;

    mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lt_ce_n(pl.ce_n), .lt_we_n(pl.we_n), .lt_oe_n(pl.oe_n), .lt_lane_n(pl.ln),
        .lt_addr(pl.a), .lt_wdata(pl.d), .lt_busy_n(pl.busy_n),
        .lt_rdata(lt_rdata), .lt_int_n(lt_int_n),
        .rt_ce_n(pr.ce_n), .rt_we_n(pr.we_n), .rt_oe_n(pr.oe_n), .rt_lane_n(pr.ln),
        .rt_addr(pr.a), .rt_wdata(pr.d), .rt_busy_n(pr.busy_n),
        .rt_rdata(rt_rdata), .rt_int_n(rt_int_n)
    );

    function automatic pin_t mk(logic ce_n, logic we_n, logic oe_n, logic [1:0] ln,
                                logic [AW-1:0] a, logic [DW-1:0] d, logic busy_n);
        pin_t p;
        p.ce_n = ce_n; p.we_n = we_n; p.oe_n = oe_n; p.ln = ln;
        p.a = a; p.d = d; p.busy_n = busy_n;
        return p;
    endfunction

    function automatic pin_t idle();
        return mk(1'b1, 1'b1, 1'b1, 2'b11, '0, '0, 1'b1);
    endfunction

    // expected read bus: R1, R2, R3, R12 (uses contents before this cycle's writes)
    function automatic logic [DW-1:0] rd_exp(pin_t p);
        logic [DW-1:0] v = '0;
        if (!p.ce_n && p.we_n && !p.oe_n) begin
            if (!p.ln[1]) v[15:8] = mem_m[p.a][15:8];
            if (!p.ln[0]) v[7:0]  = mem_m[p.a][7:0];
        end
        return v;
    endfunction

    function automatic void wr_model(pin_t p);
        if (!p.ce_n && !p.we_n && p.busy_n) begin
            if (!p.ln[1]) mem_m[p.a][15:8] = p.d[15:8];
            if (!p.ln[0]) mem_m[p.a][7:0]  = p.d[7:0];
        end
    endfunction

    task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", prev_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("lt_rdata", lt_rdata, exp_lrd);
        chk("rt_rdata", rt_rdata, exp_rrd);
        chk("lt_int_n", {15'd0, lt_int_n}, {15'd0, !fl_l});
        chk("rt_int_n", {15'd0, rt_int_n}, {15'd0, !fl_r});
    endtask

    task automatic step(pin_t l, pin_t r, string tag);
        bit s_r, c_r, s_l, c_l;
        @(negedge clk);
        compare();
        pl = l; pr = r;
        exp_lrd = rd_exp(l);
        exp_rrd = rd_exp(r);
        s_r = !l.ce_n && !l.we_n && l.busy_n && l.a == TOP;   // R4
        s_l = !r.ce_n && !r.we_n && r.busy_n && r.a == NXT;   // R5
        c_r = !r.ce_n && !r.oe_n && r.busy_n && r.a == TOP;   // R6
        c_l = !l.ce_n && !l.oe_n && l.busy_n && l.a == NXT;   // R6
        if (c_r) fl_r = 1'b0;
        if (s_r) fl_r = 1'b1;                                 // R9 set wins
        if (c_l) fl_l = 1'b0;
        if (s_l) fl_l = 1'b1;
        wr_model(r);                                           // R11: left applied last
        wr_model(l);
        prev_tag = tag;
    endtask

    function automatic pin_t rnd_pin();
        pin_t p;
        p.ce_n   = ($urandom % 5) == 0;
        p.we_n   = $urandom % 2;
        p.oe_n   = ($urandom % 4) == 0;
        p.ln     = $urandom % 4;
        p.a      = (($urandom % 3) == 0) ? (TOP - AW'($urandom % 2)) : AW'($urandom % 12);
        p.d      = DW'($urandom);
        p.busy_n = ($urandom % 6) != 0;
        return p;
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        pl = idle(); pr = idle();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // first step compares the reset state (R10)
        for (int i = 0; i < DEPTH; i++)
            step(mk(0,0,1,2'b00,AW'(i),{2'b10, AW'(i), ~8'(i)},1), idle(), "R8 fill");
        step(mk(0,1,0,2'b00,6'd5,'0,1), idle(), "R1 full read");
        step(idle(), mk(0,0,1,2'b01,6'd7,16'hABCD,1), "R2 upper write");
        step(mk(0,1,0,2'b10,6'd7,'0,1), mk(0,1,0,2'b00,6'd7,'0,1), "R2 lane read");
        step(mk(0,1,1,2'b00,6'd7,'0,1), mk(1,1,0,2'b00,6'd7,'0,1), "R3 disabled");
        step(idle(), mk(0,0,0,2'b00,TOP,16'h1111,1), "R6 clear by write");
        step(mk(0,0,1,2'b00,TOP,16'h2222,1), idle(), "R4 set right");
        step(idle(), mk(0,1,0,2'b00,TOP,'0,0), "R7 busy clear");
        step(mk(0,0,1,2'b00,6'd3,16'h3333,0), idle(), "R7 busy write");
        step(mk(0,1,0,2'b00,6'd3,'0,1), mk(0,1,0,2'b00,TOP,'0,1), "R8 mailbox read");
        step(mk(0,0,1,2'b00,TOP,16'h4444,1), mk(0,1,0,2'b00,TOP,'0,1), "R9 set wins");
        step(idle(), mk(0,0,1,2'b00,NXT,16'h5555,1), "R5 set left");
        step(mk(0,1,0,2'b00,NXT,'0,1), idle(), "R6 clear left");
        step(mk(0,0,1,2'b10,6'd9,16'h6666,1), mk(0,0,1,2'b00,6'd9,16'h7777,1), "R11 collide");
        step(mk(0,1,0,2'b00,6'd9,'0,1), idle(), "R11 readback");
        step(mk(0,0,1,2'b00,6'd10,16'h8888,1), mk(0,1,0,2'b00,6'd10,'0,1), "R12 old data");
        step(idle(), mk(0,1,0,2'b00,6'd10,'0,1), "R12 new data");
        for (int n = 0; n < 3000; n++)
            step(rnd_pin(), rnd_pin(), "R1/R2/R3/R4/R5/R6/R7/R9/R11/R12 random");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule